// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It takes the address, the access being requested, the privilege mode and the page table base. It returns the physical address, the protection rights it grants and a fault code. Most addresses are resolved by fetching one 64-bit table entry from each of three table levels, one fetch at a time, through a simple request/acknowledge memory port. Addresses in the kernel direct-mapped region are resolved at once, with no memory traffic.

A caller offers a request while `req_ready_o` is high. The block then owns the memory port until it produces a single-cycle response. Two kinds of request get special treatment. Requests whose upper address bits are not a clean sign extension are rejected before any fetch. A request with no access bits set is a probe: it returns the mapping and its rights but never a permission fault.

Top module: `pt_walker`

## Requirements
- R1: When virtual bits 63:43 are not all equal, the response carries fault code 1 (access violation), physical address 0 and rights 0, and no memory read is issued.
- R2: When the address is negative, bits 42:41 are binary 10 and the mode is 0 (kernel), the response has no fault (code 0). Its physical address is virtual bits 39:0, with virtual bit 40 placed at physical bit 43 and physical bits 42:40 cleared. Its rights are 7. No memory read is issued.
- R3: The same direct-mapped address in a mode other than 0 gives fault code 1, address 0 and rights 0, with no memory read.
- R4: Each entry is read at base + 8*index. The first base is the table base input. The first index is virtual bits 42:33, the second is bits 32:23 and the third is bits 22:13. The base for each following level is entry bits 63:32 shifted left by 13.
- R5: For a first- or second-level entry, a clear bit 0 (valid) ends the walk with fault code 2 (not valid). Otherwise a clear bit 8 (kernel read) ends it with fault code 1. In both cases address and rights are 0.
- R6: A third-level entry with bit 0 clear gives fault code 2 and rights 0, and the physical address is still entry bits 63:32 shifted left by 13.
- R7: Rights are encoded as bit 0 read, bit 1 write, bit 2 execute. Read and execute are granted by third-level entry bit 8+mode. Write is granted by bit 12+mode. The physical address is entry bits 63:32 shifted left by 13.
- R8: When the requested access is nonzero and none of its bits is granted, the fault code is 1 and the unmasked rights are returned.
- R9: Entry bits 1, 2 and 3 withdraw read, write and execute respectively from the granted rights. If this removes all of the requested access, the fault is 5 when execute was requested, else 4 when write was requested, else 3 for read. The masked rights are returned.
- R10: A request with access 0 never receives fault code 1, 3, 4 or 5 from the permission stage.
- R11: Exactly one memory read is outstanding at a time. `mem_req_o` and `mem_addr_o` hold until `mem_ack_i`. `rsp_valid_o` is a one-cycle pulse. `req_ready_o` is high only when no walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 64 | Virtual address |
| req_acc_i | input | 3 | Requested access: bit0 read, bit1 write, bit2 execute |
| req_mode_i | input | 2 | Privilege mode index, 0 is kernel |
| ptbr_i | input | 64 | First-level table base |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | 64 | Entry byte address |
| mem_ack_i | input | 1 | Read data valid |
| mem_data_i | input | 64 | Entry read data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_pa_o | output | 64 | Physical address |
| rsp_prot_o | output | 3 | Granted rights |
| rsp_fault_o | output | 3 | 0 none, 1 access, 2 not valid, 3 read, 4 write, 5 execute |

## Verification
The bench uses the default parameters: a 64-bit address with 43 implemented bits, 13-bit page offset and 10-bit level indices. With these values every index boundary, the sign window above bit 42 and the bit 40 to bit 43 remap fall on fixed positions that the bench reference computes directly. All four mode indices are reachable, so the shifted read and write enable selection is exercised from bit 8 to bit 15. The memory model adds random acknowledge delays and checks the address of every fetch against the expected level address.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned ACC_W        = 3;
  localparam int unsigned ACC_RD       = 0;
  localparam int unsigned ACC_WR       = 1;
  localparam int unsigned ACC_EX       = 2;
  localparam int unsigned PTE_W        = 64;
  localparam int unsigned PTE_VLD_BIT  = 0;
  localparam int unsigned PTE_FO_LSB   = 1;
  localparam int unsigned PTE_RE_LSB   = 8;
  localparam int unsigned PTE_WE_LSB   = 12;
  localparam int unsigned PTE_PFN_LSB  = 32;
  localparam int unsigned PTE_SZ_LOG2  = 3;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_TNV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } fault_e;

  typedef enum logic [2:0] {
    WS_IDLE = 3'd0,
    WS_L1   = 3'd1,
    WS_L2   = 3'd2,
    WS_L3   = 3'd3,
    WS_DONE = 3'd4
  } wstate_e;
endpackage

// File: rtl/pt_va_decode.sv
module pt_va_decode #(
  parameter int unsigned VA_W     = 64,
  parameter int unsigned IMPL_VA  = 43,
  parameter int unsigned PA_W     = 64,
  parameter int unsigned SP_LOW   = 40,
  parameter int unsigned SP_DST   = 43,
  parameter int unsigned MODE_W   = 2
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              sign_ok_o,
  output logic              super_o,
  output logic              super_ok_o,
  output logic [PA_W-1:0]   super_pa_o
);
  localparam int unsigned HI_W   = VA_W - IMPL_VA;
  localparam int unsigned SEL_LSB = IMPL_VA - 2;

  logic [HI_W-1:0] hi;

  always_comb begin
    hi         = va_i[VA_W-1:IMPL_VA];
    sign_ok_o  = (&hi) | ~(|hi);
    super_o    = va_i[VA_W-1] && (va_i[SEL_LSB +: 2] == 2'b10);
    super_ok_o = (mode_i == '0);
    super_pa_o = '0;
    super_pa_o[SP_LOW-1:0] = va_i[SP_LOW-1:0];
    super_pa_o[SP_DST]     = va_i[SP_LOW];
  end
endmodule

// File: rtl/pt_pte_addr.sv
module pt_pte_addr import pt_walker_pkg::*; #(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned PA_W   = 64,
  parameter int unsigned PG_OFF = 13,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned LEVELS = 3,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [PA_W-1:0]  base_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [IDX_W-1:0] idx [LEVELS];
  logic [IDX_W-1:0] sel;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    // level 0 takes the highest index field
    assign idx[g] = va_i[PG_OFF + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl_i == LVL_W'(i)) sel = idx[i];
    end
    addr_o = base_i + (PA_W'(sel) << PTE_SZ_LOG2);
  end
endmodule

// File: rtl/pt_perm_eval.sv
module pt_perm_eval import pt_walker_pkg::*; #(
  parameter int unsigned MODE_W = 2
) (
  input  logic [PTE_W-1:0]  pte_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ACC_W-1:0]  need_i,
  output logic [ACC_W-1:0]  prot_o,
  output fault_e            fault_o
);
  logic             re, we;
  logic [ACC_W-1:0] raw, masked;

  always_comb begin
    re = pte_i[PTE_RE_LSB + 32'(mode_i)];
    we = pte_i[PTE_WE_LSB + 32'(mode_i)];
    raw = '0;
    raw[ACC_RD] = re;
    raw[ACC_EX] = re;
    raw[ACC_WR] = we;
    masked  = raw & ~pte_i[PTE_FO_LSB +: ACC_W];
    prot_o  = masked;
    fault_o = FLT_NONE;
    if ((need_i != '0) && ((raw & need_i) == '0)) begin
      prot_o  = raw;
      fault_o = FLT_ACV;
    end else if ((masked & need_i) == '0) begin
      if (need_i[ACC_EX])      fault_o = FLT_FOE;
      else if (need_i[ACC_WR]) fault_o = FLT_FOW;
      else if (need_i[ACC_RD]) fault_o = FLT_FOR;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker import pt_walker_pkg::*; #(
  parameter int unsigned VA_W    = 64,
  parameter int unsigned IMPL_VA = 43,
  parameter int unsigned PA_W    = 64,
  parameter int unsigned PG_OFF  = 13,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned MODE_W  = 2,
  parameter int unsigned SP_LOW  = 40,
  parameter int unsigned SP_DST  = 43
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [ACC_W-1:0]  req_acc_i,
  input  logic [MODE_W-1:0] req_mode_i,
  input  logic [PA_W-1:0]   ptbr_i,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [PTE_W-1:0]  mem_data_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic [ACC_W-1:0]  rsp_prot_o,
  output logic [2:0]        rsp_fault_o
);
  localparam int unsigned LEVELS = 3;
  localparam int unsigned LVL_W  = $clog2(LEVELS);
  localparam int unsigned PFN_W  = PTE_W - PTE_PFN_LSB;

  wstate_e              state_q;
  logic [VA_W-1:0]      va_q;
  logic [ACC_W-1:0]     need_q;
  logic [MODE_W-1:0]    mode_q;
  logic [PA_W-1:0]      base_q;
  logic [PA_W-1:0]      pa_q;
  logic [ACC_W-1:0]     prot_q;
  fault_e               fault_q;

  logic                 sign_ok, is_super, super_ok;
  logic [PA_W-1:0]      super_pa;
  logic [LVL_W-1:0]     lvl;
  logic [PA_W-1:0]      next_base;
  logic [ACC_W-1:0]     perm_prot;
  fault_e               perm_fault;

  pt_va_decode #(
    .VA_W(VA_W), .IMPL_VA(IMPL_VA), .PA_W(PA_W),
    .SP_LOW(SP_LOW), .SP_DST(SP_DST), .MODE_W(MODE_W)
  ) u_va_decode (
    .va_i       (req_va_i),
    .mode_i     (req_mode_i),
    .sign_ok_o  (sign_ok),
    .super_o    (is_super),
    .super_ok_o (super_ok),
    .super_pa_o (super_pa)
  );

  always_comb begin
    unique case (state_q)
      WS_L2:   lvl = LVL_W'(1);
      WS_L3:   lvl = LVL_W'(2);
      default: lvl = LVL_W'(0);
    endcase
  end

  pt_pte_addr #(
    .VA_W(VA_W), .PA_W(PA_W), .PG_OFF(PG_OFF), .IDX_W(IDX_W), .LEVELS(LEVELS)
  ) u_pte_addr (
    .lvl_i  (lvl),
    .va_i   (va_q),
    .base_i (base_q),
    .addr_o (mem_addr_o)
  );

  pt_perm_eval #(.MODE_W(MODE_W)) u_perm_eval (
    .pte_i   (mem_data_i),
    .mode_i  (mode_q),
    .need_i  (need_q),
    .prot_o  (perm_prot),
    .fault_o (perm_fault)
  );

  assign next_base = PA_W'(mem_data_i[PTE_W-1:PTE_PFN_LSB]) << PG_OFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      va_q    <= '0;
      need_q  <= '0;
      mode_q  <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      prot_q  <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state_q)
        WS_IDLE: begin
          if (req_valid_i) begin
            va_q    <= req_va_i;
            need_q  <= req_acc_i;
            mode_q  <= req_mode_i;
            base_q  <= ptbr_i;
            pa_q    <= '0;
            prot_q  <= '0;
            fault_q <= FLT_NONE;
            if (!sign_ok) begin
              fault_q <= FLT_ACV;
              state_q <= WS_DONE;
            end else if (is_super) begin
              if (super_ok) begin
                pa_q   <= super_pa;
                prot_q <= '1;
              end else begin
                fault_q <= FLT_ACV;
              end
              state_q <= WS_DONE;
            end else begin
              state_q <= WS_L1;
            end
          end
        end
        WS_L1, WS_L2: begin
          if (mem_ack_i) begin
            if (!mem_data_i[PTE_VLD_BIT]) begin
              fault_q <= FLT_TNV;
              state_q <= WS_DONE;
            end else if (!mem_data_i[PTE_RE_LSB]) begin
              fault_q <= FLT_ACV;
              state_q <= WS_DONE;
            end else begin
              base_q  <= next_base;
              state_q <= (state_q == WS_L1) ? WS_L2 : WS_L3;
            end
          end
        end
        WS_L3: begin
          if (mem_ack_i) begin
            pa_q <= next_base;
            if (!mem_data_i[PTE_VLD_BIT]) begin
              fault_q <= FLT_TNV;
            end else begin
              prot_q  <= perm_prot;
              fault_q <= perm_fault;
            end
            state_q <= WS_DONE;
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == WS_IDLE);
  assign mem_req_o   = (state_q == WS_L1) || (state_q == WS_L2) || (state_q == WS_L3);
  assign rsp_valid_o = (state_q == WS_DONE);
  assign rsp_pa_o    = pa_q;
  assign rsp_prot_o  = prot_q;
  assign rsp_fault_o = fault_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)) else $error("req hold"); // R11
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o) else $error("rsp pulse"); // R11
  AST_BAD_SIGN_NO_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_valid_i && !sign_ok |=> !mem_req_o && rsp_fault_o == FLT_ACV) else $error("sign"); // R1
  AST_SUPER_NO_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_valid_i && sign_ok && is_super |=> !mem_req_o) else $error("super"); // R2
  AST_PROBE_NO_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && need_q == '0 && $past(state_q) == WS_L3 |->
      rsp_fault_o inside {FLT_NONE, FLT_TNV}) else $error("probe"); // R10
  AST_FO_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o inside {FLT_FOR, FLT_FOW, FLT_FOE} |->
      (rsp_prot_o & need_q) == '0) else $error("fo"); // R9
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [2:0]  req_acc = '0;
  logic [1:0]  req_mode = '0;
  logic [63:0] ptbr = '0;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_data = '0;
  logic        rsp_valid;
  logic [63:0] rsp_pa;
  logic [2:0]  rsp_prot;
  logic [2:0]  rsp_fault;

  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;
  logic [63:0] pte_q [3];
  logic [63:0] exp_addr [3];

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_acc_i(req_acc), .req_mode_i(req_mode), .ptbr_i(ptbr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_data_i(mem_data),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_prot_o(rsp_prot), .rsp_fault_o(rsp_fault)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder with random acknowledge delay
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        int d = int'($urandom % 3);
        repeat (d) @(negedge clk);
        if (rd_cnt < 3) begin
          chk(mem_addr == exp_addr[rd_cnt], "R4 entry address", mem_addr, exp_addr[rd_cnt]);
          mem_data = pte_q[rd_cnt];
        end else begin
          chk(1'b0, "R11 extra read", 64'(rd_cnt), 64'd3);
          mem_data = '0;
        end
        rd_cnt++;
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  function automatic void ref_walk(
    input logic [63:0] va, input logic [2:0] acc, input logic [1:0] mode, input logic [63:0] base,
    input logic [63:0] p1, input logic [63:0] p2, input logic [63:0] p3,
    output logic [63:0] pa, output logic [2:0] prot, output logic [2:0] flt, output int nrd,
    output string tag);
    logic re, we;
    logic [2:0] r;
    pa = '0; prot = '0; flt = 3'd0; nrd = 0; tag = "R7";
    exp_addr[0] = base + {51'd0, va[42:33], 3'd0};
    exp_addr[1] = {19'd0, p1[63:32], 13'd0} + {51'd0, va[32:23], 3'd0};
    exp_addr[2] = {19'd0, p2[63:32], 13'd0} + {51'd0, va[22:13], 3'd0};
    if (!(va[63:43] == '0 || va[63:43] == '1)) begin flt = 3'd1; tag = "R1"; return; end
    if (va[63] && va[42:41] == 2'b10) begin
      if (mode != 0) begin flt = 3'd1; tag = "R3"; return; end
      pa = {20'd0, va[40], 3'd0, va[39:0]}; prot = 3'd7; tag = "R2"; return;
    end
    nrd = 1;
    if (!p1[0]) begin flt = 3'd2; tag = "R5"; return; end
    if (!p1[8]) begin flt = 3'd1; tag = "R5"; return; end
    nrd = 2;
    if (!p2[0]) begin flt = 3'd2; tag = "R5"; return; end
    if (!p2[8]) begin flt = 3'd1; tag = "R5"; return; end
    nrd = 3;
    pa = {19'd0, p3[63:32], 13'd0};
    if (!p3[0]) begin flt = 3'd2; tag = "R6"; return; end
    re = p3[8 + int'(mode)];
    we = p3[12 + int'(mode)];
    r = {re, we, re};
    if (acc != 0 && (r & acc) == 0) begin flt = 3'd1; prot = r; tag = "R8"; return; end
    r = r & ~p3[3:1];
    prot = r;
    if ((r & acc) == 0) begin
      tag = (acc == 0) ? "R10" : "R9";
      if (acc[2]) flt = 3'd5;
      else if (acc[1]) flt = 3'd4;
      else if (acc[0]) flt = 3'd3;
    end else if (p3[3:1] != 0) tag = "R9";
  endfunction

  task automatic run_one(input logic [63:0] va, input logic [2:0] acc, input logic [1:0] mode,
                         input logic [63:0] base, input logic [63:0] p1, input logic [63:0] p2,
                         input logic [63:0] p3);
    logic [63:0] epa; logic [2:0] eprot, eflt; int nrd; string tag;
    ref_walk(va, acc, mode, base, p1, p2, p3, epa, eprot, eflt, nrd, tag);
    pte_q[0] = p1; pte_q[1] = p2; pte_q[2] = p3;
    rd_cnt = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready when idle", 64'(req_ready), 64'd1);
    req_va = va; req_acc = acc; req_mode = mode; ptbr = base; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_fault == eflt, {tag, " fault"}, 64'(rsp_fault), 64'(eflt));
    chk(rsp_pa == epa, {tag, " address"}, rsp_pa, epa);
    chk(rsp_prot == eprot, {tag, " rights"}, 64'(rsp_prot), 64'(eprot));
    chk(rd_cnt == nrd, {tag, " read count"}, 64'(rd_cnt), 64'(nrd));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 response pulse", 64'(rsp_valid), 64'd0);
  endtask

  function automatic logic [63:0] mk_pte(input logic [31:0] pfn, input logic [15:0] lo);
    return {pfn, 16'd0, lo};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] base, va, p1, p2, p3;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R11 reset state",
        {61'd0, req_ready, rsp_valid, mem_req}, 64'h4);
    rst_n = 1'b1;
    base = 64'h0000_0000_0040_0000;
    p1 = mk_pte(32'h0000_0123, 16'h0101);
    p2 = mk_pte(32'h0000_0456, 16'h0101);
    // R1 bad sign
    run_one(64'h0010_0000_0000_0000, 3'b001, 2'd0, base, p1, p2, 64'h0);
    // R2 superpage with bit 40 set
    run_one(64'hFFFF_FD12_3456_7890, 3'b010, 2'd0, base, p1, p2, 64'h0);
    run_one(64'hFFFF_FC12_3456_7890, 3'b100, 2'd0, base, p1, p2, 64'h0);
    // R3 superpage in user mode
    run_one(64'hFFFF_FD12_3456_7890, 3'b001, 2'd3, base, p1, p2, 64'h0);
    // R5 first-level invalid and no kernel read
    run_one(64'h0000_0123_4567_8000, 3'b001, 2'd0, base, mk_pte(32'h5, 16'h0100), p2, 64'h0);
    run_one(64'h0000_0123_4567_8000, 3'b001, 2'd0, base, mk_pte(32'h5, 16'h0001), p2, 64'h0);
    run_one(64'h0000_0123_4567_8000, 3'b001, 2'd0, base, p1, mk_pte(32'h6, 16'h0001), 64'h0);
    // R6 last level invalid
    run_one(64'h0000_0123_4567_8000, 3'b001, 2'd0, base, p1, p2, mk_pte(32'h789, 16'hFF00));
    // R7 read granted in mode 2
    run_one(64'h0000_0765_4321_0000, 3'b001, 2'd2, base, p1, p2, mk_pte(32'hABC, 16'h0401));
    // R8 write not granted
    run_one(64'h0000_0765_4321_0000, 3'b010, 2'd1, base, p1, p2, mk_pte(32'hABC, 16'h0201));
    // R9 execute withdrawn, read withdrawn
    run_one(64'h0000_0765_4321_0000, 3'b100, 2'd0, base, p1, p2, mk_pte(32'hABC, 16'h1109));
    run_one(64'h0000_0765_4321_0000, 3'b001, 2'd0, base, p1, p2, mk_pte(32'hABC, 16'h1103));
    run_one(64'h0000_0765_4321_0000, 3'b010, 2'd3, base, p1, p2, mk_pte(32'hABC, 16'h8805));
    // R10 probe with no rights
    run_one(64'h0000_0765_4321_0000, 3'b000, 2'd0, base, p1, p2, mk_pte(32'hABC, 16'h000F));
    for (int n = 0; n < 400; n++) begin
      logic [2:0] acc;
      int k = int'($urandom % 8);
      va = {$urandom, $urandom};
      if (k == 0) va[50] = ~va[49];
      else if (k == 1) begin va[63:43] = '1; va[42:41] = 2'b10; end
      else va[63:43] = {21{va[42]}};
      base = {32'd0, $urandom} & 64'h0000_0000_FFFF_FFF8;
      p1 = {$urandom, $urandom}; p2 = {$urandom, $urandom}; p3 = {$urandom, $urandom};
      if ($urandom % 8 != 0) p1[8] = 1'b1;
      if ($urandom % 8 != 0) p1[0] = 1'b1;
      if ($urandom % 8 != 0) p2[8] = 1'b1;
      if ($urandom % 8 != 0) p2[0] = 1'b1;
      if ($urandom % 8 != 0) p3[0] = 1'b1;
      if ($urandom % 2 != 0) p3[3:1] = 3'b000;
      case ($urandom % 4)
        0: acc = 3'b000;
        1: acc = 3'b001;
        2: acc = 3'b010;
        default: acc = 3'b100;
      endcase
      run_one(va, acc, 2'($urandom), base, p1, p2, p3);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule